// File: doc/BRIEF.md
# Two-Rank DDR Address Decoder

This block sits in front of a DDR controller's command logic. It accepts a memory request made of a byte address and a read/write flag, and decides which of two contiguous DDR ranks the address falls in. It then subtracts that rank's start address and splits the remaining offset into row, bank and column fields. Banks interleave every 1 KiB. The bit positions of the bank and row fields move by one bit depending on whether the attached devices have 256 or 512 columns per row, and a parameter fixes that choice at build time.

Three configuration registers place the ranks: the start of rank 0, the end of rank 0, and the end of rank 1. Rank 1 always begins where rank 0 ends. A request that hits neither rank is still passed downstream as a normal access. The request is flagged as erroneous and decoded against rank 0's start. The first such request is logged in a sticky error record, which software clears by writing a one to its flag bit.

Requests pass through a valid/ready handshake with one register stage, so a decoded request appears one cycle after it is accepted.

Top module: `ddr_rank_mapper`

## Requirements
- R1: After reset, `out_valid` is 0 and every readable configuration location (selects 0 to 4) returns 0.
- R2: An address `a` with `r0_lo <= a < r0_hi` is decoded with `out_rank` = 0 and `out_err` = 0, using offset `a - r0_lo`.
- R3: An address `a` with `r0_hi <= a < r1_hi` is decoded with `out_rank` = 1 and `out_err` = 0, using offset `a - r0_hi`.
- R4: With `COLS` = 256, the fields are column = offset[9:2], bank = offset[11:10] and row = offset[12 +: ROW_W].
- R5: With `COLS` = 512, the fields are column[7:0] = offset[9:2], column[8] = offset[10], bank = offset[12:11] and row = offset[13 +: ROW_W].
- R6: An address inside neither rank is still forwarded with its write flag. It has `out_err` = 1 and `out_rank` = 0, and its fields are taken from offset `a - r0_lo` (modulo 2^AW).
- R7: When a request that hits neither rank is accepted while the error flag is clear, the error flag is set and the error record stores that address and its write flag. Later errors leave the record unchanged while the flag stays set.
- R8: A configuration write to select 3 with bit 0 = 1 clears the error flag. The same write with bit 0 = 0 has no effect. If an erroneous request is accepted in the same cycle as a clearing write, the new error is recorded and the flag stays set.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted request appears at the outputs on the next cycle. The outputs stay unchanged while `out_valid` is 1 and `out_ready` is 0.
- R10: The configuration selects are 0 = rank 0 start, 1 = rank 0 end, 2 = rank 1 end, 3 = error status (bit 0 = flag, bit 1 = write flag of the recorded request) and 4 = recorded error address. Selects 5 to 7 read as 0. `cfg_rdata` shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | AW | Request byte address |
| in_write | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Decoded request present |
| out_ready | input | 1 | Downstream takes the decoded request |
| out_rank | output | 1 | Selected rank |
| out_row | output | ROW_W | Row field |
| out_bank | output | 2 | Bank field |
| out_col | output | log2(COLS) | Column field |
| out_write | output | 1 | Forwarded write flag |
| out_err | output | 1 | Address hit neither rank |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| cfg_rdata | output | AW | Configuration read data |

## Verification
The bench builds two copies side by side, sharing every input: one with `COLS` = 256 and one with `COLS` = 512, both with AW = 32 and ROW_W = 14. Running both copies on the same traffic exercises both generate variants of the field split in one run. It also shows the bank and row boundaries moving from offset bits 10 and 12 to bits 11 and 13. The 14-bit row lets offsets of several MiB in the random phase reach high row bits. Random back-pressure keeps the stall path busy, and addresses are drawn just beyond rank 1 so that errors and error capture occur often.

// File: rtl/ddr_map_pkg.sv
package ddr_map_pkg;
   // configuration select codes
   typedef enum logic [2:0] {
      SEL_R0_LO    = 3'd0,
      SEL_R0_HI    = 3'd1,
      SEL_R1_HI    = 3'd2,
      SEL_ERR_STAT = 3'd3,
      SEL_ERR_ADDR = 3'd4
   } cfg_sel_e;

   localparam int BANK_W    = 2;
   localparam int COL_LSB   = 2;   // 4 bytes per column address
   localparam int COL_LOW_W = 8;   // column bits below the interleave point
   localparam int ILV_LSB   = 10;  // 1 KiB interleave
endpackage

// File: rtl/ddr_rank_window.sv
module ddr_rank_window #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] req_addr,
   input  logic [AW-1:0] r0_lo,
   input  logic [AW-1:0] r0_hi,
   input  logic [AW-1:0] r1_hi,
   output logic          sel_r1,
   output logic          miss,
   output logic [AW-1:0] offset
);
   logic in_r0, in_r1;

   assign in_r0  = (req_addr >= r0_lo) && (req_addr < r0_hi);
   assign in_r1  = (req_addr >= r0_hi) && (req_addr < r1_hi);
   assign sel_r1 = in_r1 && !in_r0;
   assign miss   = !(in_r0 || in_r1);
   // misses fall back to rank 0 base
   assign offset = req_addr - (sel_r1 ? r0_hi : r0_lo);
endmodule

// File: rtl/ddr_addr_split.sv
module ddr_addr_split
   import ddr_map_pkg::*;
#(
   parameter int AW    = 32,
   parameter int ROW_W = 14,
   parameter int COLS  = 256,
   localparam int COL_W = $clog2(COLS)
) (
   input  logic [AW-1:0]     offset,
   output logic [ROW_W-1:0]  row,
   output logic [BANK_W-1:0] bank,
   output logic [COL_W-1:0]  col
);
   localparam int XC      = COL_W - COL_LOW_W;          // column bits above interleave
   localparam int BANK_LSB = ILV_LSB + XC;
   localparam int ROW_LSB  = BANK_LSB + BANK_W;

   generate
      if (XC == 0) begin : g_narrow
         assign col = offset[COL_LSB +: COL_LOW_W];
      end else begin : g_wide
         assign col = {offset[ILV_LSB +: XC], offset[COL_LSB +: COL_LOW_W]};
      end
   endgenerate

   assign bank = offset[BANK_LSB +: BANK_W];
   assign row  = offset[ROW_LSB +: ROW_W];
endmodule

// File: rtl/ddr_map_cfg.sv
module ddr_map_cfg
   import ddr_map_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   output logic [AW-1:0] cfg_rdata,
   input  logic          cap_req,
   input  logic [AW-1:0] cap_addr,
   input  logic          cap_write,
   output logic [AW-1:0] r0_lo,
   output logic [AW-1:0] r0_hi,
   output logic [AW-1:0] r1_hi
);
   logic          err_flag, err_wr;
   logic [AW-1:0] err_addr;
   logic          clr, take;

   assign clr  = cfg_we && (cfg_sel == SEL_ERR_STAT) && cfg_wdata[0];
   assign take = cap_req && (!err_flag || clr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r0_lo    <= '0;
         r0_hi    <= '0;
         r1_hi    <= '0;
         err_flag <= 1'b0;
         err_wr   <= 1'b0;
         err_addr <= '0;
      end else begin
         if (cfg_we) begin
            case (cfg_sel)
               SEL_R0_LO: r0_lo <= cfg_wdata;
               SEL_R0_HI: r0_hi <= cfg_wdata;
               SEL_R1_HI: r1_hi <= cfg_wdata;
               default: ;
            endcase
         end
         if (take) begin
            err_flag <= 1'b1;
            err_addr <= cap_addr;
            err_wr   <= cap_write;
         end else if (clr) begin
            err_flag <= 1'b0;
         end
      end
   end

   always_comb begin
      case (cfg_sel)
         SEL_R0_LO:    cfg_rdata = r0_lo;
         SEL_R0_HI:    cfg_rdata = r0_hi;
         SEL_R1_HI:    cfg_rdata = r1_hi;
         SEL_ERR_STAT: cfg_rdata = {{(AW-2){1'b0}}, err_wr, err_flag};
         SEL_ERR_ADDR: cfg_rdata = err_addr;
         default:      cfg_rdata = '0;
      endcase
   end

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !clr |=> err_flag);
   // R7
   first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req && !err_flag |=> err_flag && (err_addr == $past(cap_addr)));
   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !cap_req |=> !err_flag);
endmodule

// File: rtl/ddr_rank_mapper.sv
module ddr_rank_mapper
   import ddr_map_pkg::*;
#(
   parameter int AW    = 32,
   parameter int ROW_W = 14,
   parameter int COLS  = 256,
   localparam int COL_W = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [AW-1:0]    in_addr,
   input  logic             in_write,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_rank,
   output logic [ROW_W-1:0] out_row,
   output logic [1:0]       out_bank,
   output logic [COL_W-1:0] out_col,
   output logic             out_write,
   output logic             out_err,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [AW-1:0]    cfg_wdata,
   output logic [AW-1:0]    cfg_rdata
);
   localparam int ROW_LSB = ILV_LSB + (COL_W - COL_LOW_W) + BANK_W;

   generate
      if (COLS != 256 && COLS != 512) begin : g_bad_cols
         $error("ddr_rank_mapper: COLS must be 256 or 512");
      end
      if (AW < ROW_LSB + ROW_W) begin : g_bad_aw
         $error("ddr_rank_mapper: AW too small for row field");
      end
   endgenerate

   logic [AW-1:0]     r0_lo, r0_hi, r1_hi, offset;
   logic              sel_r1, miss, acc;
   logic [ROW_W-1:0]  d_row;
   logic [BANK_W-1:0] d_bank;
   logic [COL_W-1:0]  d_col;

   assign in_ready = !out_valid || out_ready;
   assign acc      = in_valid && in_ready;

   ddr_rank_window #(.AW(AW)) u_window (
      .req_addr (in_addr),
      .r0_lo    (r0_lo),
      .r0_hi    (r0_hi),
      .r1_hi    (r1_hi),
      .sel_r1   (sel_r1),
      .miss     (miss),
      .offset   (offset)
   );

   ddr_addr_split #(.AW(AW), .ROW_W(ROW_W), .COLS(COLS)) u_split (
      .offset (offset),
      .row    (d_row),
      .bank   (d_bank),
      .col    (d_col)
   );

   ddr_map_cfg #(.AW(AW)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cap_req   (acc && miss),
      .cap_addr  (in_addr),
      .cap_write (in_write),
      .r0_lo     (r0_lo),
      .r0_hi     (r0_hi),
      .r1_hi     (r1_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rank  <= 1'b0;
         out_row   <= '0;
         out_bank  <= '0;
         out_col   <= '0;
         out_write <= 1'b0;
         out_err   <= 1'b0;
      end else if (acc) begin
         out_valid <= 1'b1;
         out_rank  <= sel_r1;
         out_row   <= d_row;
         out_bank  <= d_bank;
         out_col   <= d_col;
         out_write <= in_write;
         out_err   <= miss;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R9
   hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_bank)
         && $stable(out_col) && $stable(out_rank) && $stable(out_write) && $stable(out_err));
   // R9
   accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
   // R6
   err_rank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err |-> !out_rank);
   // R3
   rank1_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_rank |-> !out_err);
endmodule

// File: tb/ddr_rank_mapper_bench.sv
module ddr_rank_mapper_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b1;
   logic [31:0] in_addr = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;

   logic        a_ready, a_valid, a_rank, a_write, a_err;
   logic [13:0] a_row;
   logic [1:0]  a_bank;
   logic [7:0]  a_col;
   logic [31:0] a_rdata;
   logic        b_ready, b_valid, b_rank, b_write, b_err;
   logic [13:0] b_row;
   logic [1:0]  b_bank;
   logic [8:0]  b_col;
   logic [31:0] b_rdata;

   int n_vec = 0, n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   ddr_rank_mapper #(.AW(32), .ROW_W(14), .COLS(256)) u_ddr_rank_mapper (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_ready),
      .in_addr(in_addr), .in_write(in_write), .out_valid(a_valid), .out_ready(out_ready),
      .out_rank(a_rank), .out_row(a_row), .out_bank(a_bank), .out_col(a_col),
      .out_write(a_write), .out_err(a_err), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(a_rdata));

   ddr_rank_mapper #(.AW(32), .ROW_W(14), .COLS(512)) u_ddr_rank_mapper_c512 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_ready),
      .in_addr(in_addr), .in_write(in_write), .out_valid(b_valid), .out_ready(out_ready),
      .out_rank(b_rank), .out_row(b_row), .out_bank(b_bank), .out_col(b_col),
      .out_write(b_write), .out_err(b_err), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(b_rdata));

   // ---------------- reference model ----------------
   logic [31:0] m_lo = '0, m_hi0 = '0, m_hi1 = '0;
   bit          m_valid = 0, m_flag = 0, m_ewr = 0;
   logic [31:0] m_eaddr = '0;
   bit          m_rank [2], m_err [2], m_wr [2];
   logic [31:0] m_row [2], m_bank [2], m_col [2];

   task automatic decode(input logic [31:0] a, input bit wide, output bit rk,
                         output logic [31:0] row, output logic [31:0] bank,
                         output logic [31:0] col, output bit er);
      logic [31:0] off;
      er = 0; rk = 0;
      if (a >= m_lo && a < m_hi0) off = a - m_lo;
      else if (a >= m_hi0 && a < m_hi1) begin rk = 1; off = a - m_hi0; end
      else begin er = 1; off = a - m_lo; end
      if (!wide) begin
         col  = (off / 4) % 256;
         bank = (off / 1024) % 4;
         row  = (off / 4096) % 16384;
      end else begin
         col  = (off / 4) % 256 + ((off / 1024) % 2) * 256;
         bank = (off / 2048) % 4;
         row  = (off / 8192) % 16384;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_flag = 0; m_ewr = 0; m_eaddr = '0;
         m_lo = '0; m_hi0 = '0; m_hi1 = '0;
      end else begin
         bit acc, clr, e;
         acc = in_valid && (!m_valid || out_ready);
         clr = cfg_we && cfg_sel == 3'd3 && cfg_wdata[0];
         e = 0;
         if (acc) begin
            for (int k = 0; k < 2; k++) begin
               decode(in_addr, k == 1, m_rank[k], m_row[k], m_bank[k], m_col[k], m_err[k]);
               m_wr[k] = in_write;
            end
            e = m_err[0];
            m_valid = 1;
         end else if (out_ready) m_valid = 0;
         if (acc && e && (!m_flag || clr)) begin
            m_flag = 1; m_eaddr = in_addr; m_ewr = in_write;
         end else if (clr) m_flag = 0;
         if (cfg_we) begin
            if (cfg_sel == 3'd0) m_lo = cfg_wdata;
            if (cfg_sel == 3'd1) m_hi0 = cfg_wdata;
            if (cfg_sel == 3'd2) m_hi1 = cfg_wdata;
         end
      end
   end

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // per-clock comparison, away from both edges
   always @(negedge clk) begin
      #(CLK_P/4);
      if (rst_n) begin
         string ft0, ft1;
         chk("R9", "in_ready c256", {63'd0, a_ready}, {63'd0, !m_valid || out_ready});
         chk("R9", "in_ready c512", {63'd0, b_ready}, {63'd0, !m_valid || out_ready});
         chk("R9", "out_valid c256", {63'd0, a_valid}, {63'd0, m_valid});
         chk("R9", "out_valid c512", {63'd0, b_valid}, {63'd0, m_valid});
         if (m_valid) begin
            ft0 = m_err[0] ? "R6" : "R4";
            ft1 = m_err[1] ? "R6" : "R5";
            chk(m_err[0] ? "R6" : (m_rank[0] ? "R3" : "R2"), "rank c256", {63'd0, a_rank}, {63'd0, m_rank[0]});
            chk(m_err[1] ? "R6" : (m_rank[1] ? "R3" : "R2"), "rank c512", {63'd0, b_rank}, {63'd0, m_rank[1]});
            chk("R6", "err c256", {63'd0, a_err}, {63'd0, m_err[0]});
            chk("R6", "err c512", {63'd0, b_err}, {63'd0, m_err[1]});
            chk("R6", "write c256", {63'd0, a_write}, {63'd0, m_wr[0]});
            chk("R6", "write c512", {63'd0, b_write}, {63'd0, m_wr[1]});
            chk(ft0, "row c256", {50'd0, a_row}, {32'd0, m_row[0]});
            chk(ft0, "bank c256", {62'd0, a_bank}, {32'd0, m_bank[0]});
            chk(ft0, "col c256", {56'd0, a_col}, {32'd0, m_col[0]});
            chk(ft1, "row c512", {50'd0, b_row}, {32'd0, m_row[1]});
            chk(ft1, "bank c512", {62'd0, b_bank}, {32'd0, m_bank[1]});
            chk(ft1, "col c512", {55'd0, b_col}, {32'd0, m_col[1]});
         end
      end
   end

   // ---------------- stimulus ----------------
   localparam logic [31:0] LO  = 32'h0010_0000;
   localparam logic [31:0] HI0 = 32'h0030_0000;
   localparam logic [31:0] HI1 = 32'h0050_0000;

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   task automatic cfg_write(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic cfg_read(input string tag, input logic [2:0] s, input logic [31:0] exp);
      @(negedge clk); cfg_sel = s; #1;
      chk(tag, "cfg_rdata c256", {32'd0, a_rdata}, {32'd0, exp});
      chk(tag, "cfg_rdata c512", {32'd0, b_rdata}, {32'd0, exp});
   endtask

   task automatic send(input logic [31:0] a, input bit w);
      @(negedge clk); in_valid = 1; in_addr = a; in_write = w; out_ready = 1;
      @(negedge clk); in_valid = 0;
   endtask

   initial begin
      #(CLK_P * 60000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1", "out_valid in reset", {63'd0, a_valid | b_valid}, 64'd0);
      rst_n = 1;
      for (int s = 0; s < 8; s++) cfg_read("R1", s[2:0], 32'd0);

      cfg_write(3'd0, LO);
      cfg_write(3'd1, HI0);
      cfg_write(3'd2, HI1);
      cfg_read("R10", 3'd0, LO);
      cfg_read("R10", 3'd1, HI0);
      cfg_read("R10", 3'd2, HI1);
      cfg_write(3'd5, 32'hFFFF_FFFF);
      cfg_read("R10", 3'd5, 32'd0);

      // directed interleave points, R2 R4 R5
      send(LO + 32'h800, 0);
      send(LO + 32'hC00, 1);
      send(LO + 32'h1000, 0);
      send(LO + 32'h400, 0);
      send(LO + 32'h2000, 1);
      send(LO + 32'h24, 0);
      send(HI0 - 4, 0);
      // R3 rank 1 from its own base
      send(HI0, 1);
      send(HI0 + 32'h1404, 0);
      send(HI1 - 4, 1);
      // R6 R7 misses
      send(HI1, 1);
      send(LO - 4, 0);
      cfg_read("R7", 3'd3, 32'd3);
      cfg_read("R7", 3'd4, HI1);
      // R8 writing zero leaves the record
      cfg_write(3'd3, 32'd0);
      cfg_read("R8", 3'd3, 32'd3);
      cfg_write(3'd3, 32'd1);
      cfg_read("R8", 3'd3, 32'd2);
      send(32'h0000_0100, 0);
      cfg_read("R7", 3'd3, 32'd1);
      cfg_read("R7", 3'd4, 32'h0000_0100);
      // R8 clear and new error in the same cycle
      @(negedge clk);
      cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = 32'd1;
      in_valid = 1; in_addr = 32'h0070_0000; in_write = 1; out_ready = 1;
      @(negedge clk); cfg_we = 0; in_valid = 0;
      cfg_read("R8", 3'd3, 32'd3);
      cfg_read("R8", 3'd4, 32'h0070_0000);

      // R9 stall: hold output with back-pressure
      @(negedge clk); out_ready = 0; in_valid = 1; in_addr = LO + 32'h1234; in_write = 0;
      @(negedge clk); in_addr = LO + 32'h5678;
      repeat (3) @(negedge clk);
      out_ready = 1;
      @(negedge clk); in_valid = 0;

      // random traffic with back-pressure
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         in_valid  = ($urandom_range(0, 3) != 0);
         in_addr   = $urandom_range(32'h000F_F000, 32'h0050_2000);
         in_write  = $urandom_range(0, 1);
         out_ready = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 200) == 0) begin
            cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = 32'd1;
         end else cfg_we = 0;
      end
      @(negedge clk); in_valid = 0; cfg_we = 0; out_ready = 1;
      repeat (3) @(negedge clk);
      cfg_read("R7", 3'd3, {30'd0, m_ewr, m_flag});
      cfg_read("R7", 3'd4, m_eaddr);
      finish_run();
   end
endmodule